// File: doc/BRIEF.md
# Hart Interrupt Router

The block collects a set of external interrupt lines and presents them to several hart contexts. A context is one privilege level of one hardware thread, and each context has a single interrupt output. Every source has a programmable priority. Every context has its own enable bitmap and its own priority floor. A context takes the best interrupt that is currently open to it by reading its claim word. Once its handler has run, the context writes the same ID back to that word to release the source.

Each source passes through a gateway that is fixed at build time as level-sensitive or rising-edge-sensitive. An edge gateway can also be built to keep a small saturating tally of edges that arrive while its source is busy and to replay them one at a time. The alternative build drops such edges. Software reaches all configuration and the claim/complete words through a plain word-addressed read/write port. Reads return data combinationally, and a claim read takes effect at the clock edge that ends the read cycle.

Top module: `hart_irq_router`

## Requirements
- R1: The register space is addressed by 7-bit word addresses. Bits 6:5 select the region: 0 holds the priority of source k at index k, 1 holds the enable bitmap of context c, 2 holds the threshold of context c, and 3 holds the claim/complete word of context c. Bits 4:0 carry the index. All registers reset to zero, every interrupt output is low after reset, and unused addresses read as zero.
- R2: A context's interrupt output is high exactly when some source is pending, is enabled for that context, and has a priority strictly above that context's threshold. A source with priority 0 therefore never raises an output.
- R3: A claim read returns the ID of the eligible source with the highest priority. If priorities are equal, the lowest ID is returned. If no source is eligible, the read returns 0.
- R4: A claim read that returns a non-zero ID clears that source's pending state and puts the source in service. A source in service is not pending again until its ID is written to a claim/complete word.
- R5: A level source becomes pending while its input is high and it is neither pending nor in service. If the input is still high after completion, the source becomes pending again. If the input is low at completion, it does not.
- R6: An edge source becomes pending on a rising edge of its input. An input that stays high produces only one request.
- R7: In a queueing edge gateway, edges that arrive while the source is pending or in service are counted, up to 3 with the default tally width. Each completion that finds a non-zero tally makes the source pending again and decrements the tally.
- R8: In a discarding edge gateway, edges that arrive while the source is pending or in service are dropped.
- R9: ID 0 is reserved. The priority word at index 0 reads 0 and ignores writes, and enable bit 0 always reads 0. Writing 0, or an ID above the source count, to a claim/complete word has no effect.
- R10: Enable bitmaps are independent per context. Bit k of a context's bitmap gates source k for that context only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irqSrc | input | NUM_SRC | External interrupt lines, bit k is source k (k = 1..NUM_SRC) |
| regWr | input | 1 | Register write strobe |
| regRd | input | 1 | Register read strobe (a claim takes effect on this cycle's edge) |
| regAddr | input | 7 | Word address: region in bits 6:5, index in bits 4:0 |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Combinational read data for regAddr |
| irqOut | output | NUM_CTX | Interrupt request, one per context |

## Verification
The hardest condition to reach from the ports is a queueing edge gateway whose tally has saturated while its handler is still open. Reaching it requires a claim first, followed by more rising edges than the tally can hold, all before any completion. The bench claims the edge source, sends four isolated one-cycle pulses, and then alternates completions with claim reads. It expects exactly three replays followed by an empty claim. A related hard case is a completion carrying a reserved or out-of-range ID. The bench holds a level source in service with its input high, so a bogus completion that did act would show up as a fresh pending request on the next claim read.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int IDX_W  = 5;
  localparam int ADDR_W = IDX_W + 2;
  localparam int DATA_W = 32;

  localparam logic [1:0] REGION_PRIO  = 2'd0;
  localparam logic [1:0] REGION_EN    = 2'd1;
  localparam logic [1:0] REGION_THR   = 2'd2;
  localparam logic [1:0] REGION_CLAIM = 2'd3;

  typedef enum logic [2:0] {
    RD_NONE, RD_PRIO, RD_EN, RD_THR, RD_CLAIM
  } rdSel_e;

  // strobes from register decode to datapath
  typedef struct packed {
    logic               prioWr;
    logic               enWr;
    logic               thrWr;
    logic               complWr;
    logic               claimRd;
    rdSel_e             rdSel;
    logic [IDX_W-1:0]   idx;
    logic [DATA_W-1:0]  wdata;
  } regStrobe_t;
endpackage

// File: rtl/irqc_gateway.sv
module irqc_gateway #(
  parameter bit IS_EDGE = 1'b0,
  parameter bit QUEUE   = 1'b0,
  parameter int QCNT_W  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rawIn,
  input  logic claimHit,
  input  logic completeHit,
  output logic pending,
  output logic inService
);
  logic prevIn;
  logic edgeSeen;
  logic trigger;
  logic backlog;

  assign edgeSeen = rawIn & ~prevIn;
  assign trigger  = IS_EDGE ? edgeSeen : rawIn;

  generate
    if (IS_EDGE && QUEUE) begin : g_queue
      logic [QCNT_W-1:0] tally;
      logic incr;
      logic decr;
      assign incr = edgeSeen && (pending || inService) && (tally != '1);
      assign decr = completeHit && inService && (tally != '0);
      always_ff @(posedge clk) begin
        if (!rst_n)             tally <= '0;
        else if (incr && !decr) tally <= tally + 1'b1;
        else if (decr && !incr) tally <= tally - 1'b1;
      end
      assign backlog = (tally != '0);
    end else begin : g_noqueue
      assign backlog = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prevIn    <= 1'b0;
      pending   <= 1'b0;
      inService <= 1'b0;
    end else begin
      prevIn <= rawIn;
      if (claimHit && pending) begin
        pending   <= 1'b0;
        inService <= 1'b1;
      end else if (completeHit && inService) begin
        inService <= 1'b0;
        pending   <= backlog;
      end else if (!pending && !inService && trigger) begin
        pending <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/irqc_arbiter.sv
module irqc_arbiter #(
  parameter int NUM_SRC = 8,
  parameter int PRIO_W  = 3,
  parameter int ID_W    = 4
) (
  input  logic [NUM_SRC:1]             cand,
  input  logic [NUM_SRC:1][PRIO_W-1:0] prio,
  input  logic [PRIO_W-1:0]            threshold,
  output logic [ID_W-1:0]              winId
);
  logic [PRIO_W-1:0] bestP;

  // ascending scan with strict compare: ties keep the lower ID,
  // and the threshold itself is never good enough
  always_comb begin
    bestP = threshold;
    winId = '0;
    for (int i = 1; i <= NUM_SRC; i++) begin
      if (cand[i] && (prio[i] > bestP)) begin
        bestP = prio[i];
        winId = ID_W'(i);
      end
    end
  end
endmodule

// File: rtl/irqc_control.sv
module irqc_control
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_CTX = 2
) (
  input  logic              regWr,
  input  logic              regRd,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWdata,
  output regStrobe_t        strobe
);
  logic [1:0]       region;
  logic [IDX_W-1:0] idx;
  logic             srcOk;
  logic             ctxOk;

  assign region = regAddr[ADDR_W-1:IDX_W];
  assign idx    = regAddr[IDX_W-1:0];
  assign srcOk  = (idx != '0) && (int'(idx) <= NUM_SRC);
  assign ctxOk  = (int'(idx) < NUM_CTX);

  always_comb begin
    strobe       = '0;
    strobe.idx   = idx;
    strobe.wdata = regWdata;
    strobe.rdSel = RD_NONE;
    case (region)
      REGION_PRIO: begin
        strobe.prioWr = regWr && srcOk;
        if (srcOk) strobe.rdSel = RD_PRIO;
      end
      REGION_EN: begin
        strobe.enWr = regWr && ctxOk;
        if (ctxOk) strobe.rdSel = RD_EN;
      end
      REGION_THR: begin
        strobe.thrWr = regWr && ctxOk;
        if (ctxOk) strobe.rdSel = RD_THR;
      end
      default: begin
        strobe.complWr = regWr && ctxOk;
        strobe.claimRd = regRd && !regWr && ctxOk;
        if (ctxOk) strobe.rdSel = RD_CLAIM;
      end
    endcase
  end
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int QCNT_W  = 2,
  parameter logic [NUM_SRC-1:0] EDGE_MASK  = '0,
  parameter logic [NUM_SRC-1:0] QUEUE_MASK = '0
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC:1]   irqSrc,
  input  regStrobe_t         strobe,
  output logic [DATA_W-1:0]  regRdata,
  output logic [NUM_CTX-1:0] irqOut,
  output logic [NUM_SRC:1]   pendVec,
  output logic [NUM_SRC:1]   busyVec
);
  localparam int ID_W = $clog2(NUM_SRC + 1);

  logic [NUM_SRC:1][PRIO_W-1:0] prioReg;
  logic [NUM_CTX-1:0][NUM_SRC:1] enReg;
  logic [NUM_CTX-1:0][PRIO_W-1:0] thrReg;
  logic [NUM_CTX-1:0][ID_W-1:0] winId;
  logic [ID_W-1:0] claimId;
  logic [ID_W-1:0] complId;
  logic [NUM_SRC:1] claimHit;
  logic [NUM_SRC:1] completeHit;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prioReg <= '0;
      enReg   <= '0;
      thrReg  <= '0;
    end else begin
      for (int i = 1; i <= NUM_SRC; i++)
        if (strobe.prioWr && strobe.idx == IDX_W'(i))
          prioReg[i] <= strobe.wdata[PRIO_W-1:0];
      for (int c = 0; c < NUM_CTX; c++) begin
        if (strobe.enWr && strobe.idx == IDX_W'(c))
          enReg[c] <= strobe.wdata[NUM_SRC:1];
        if (strobe.thrWr && strobe.idx == IDX_W'(c))
          thrReg[c] <= strobe.wdata[PRIO_W-1:0];
      end
    end
  end

  generate
    for (genvar g = 1; g <= NUM_SRC; g++) begin : g_src
      irqc_gateway #(
        .IS_EDGE (EDGE_MASK[g-1]),
        .QUEUE   (QUEUE_MASK[g-1]),
        .QCNT_W  (QCNT_W)
      ) u_gw (
        .clk         (clk),
        .rst_n       (rst_n),
        .rawIn       (irqSrc[g]),
        .claimHit    (claimHit[g]),
        .completeHit (completeHit[g]),
        .pending     (pendVec[g]),
        .inService   (busyVec[g])
      );
    end
    for (genvar c = 0; c < NUM_CTX; c++) begin : g_ctx
      irqc_arbiter #(
        .NUM_SRC (NUM_SRC),
        .PRIO_W  (PRIO_W),
        .ID_W    (ID_W)
      ) u_arb (
        .cand      (pendVec & enReg[c]),
        .prio      (prioReg),
        .threshold (thrReg[c]),
        .winId     (winId[c])
      );
      assign irqOut[c] = (winId[c] != '0);
    end
  endgenerate

  always_comb begin
    claimId = '0;
    for (int c = 0; c < NUM_CTX; c++)
      if (strobe.idx == IDX_W'(c)) claimId = winId[c];
  end

  assign complId = strobe.wdata[ID_W-1:0];

  always_comb begin
    for (int i = 1; i <= NUM_SRC; i++) begin
      claimHit[i]    = strobe.claimRd && (claimId == ID_W'(i));
      completeHit[i] = strobe.complWr && (complId == ID_W'(i))
                       && (strobe.wdata[DATA_W-1:ID_W] == '0);
    end
  end

  always_comb begin
    regRdata = '0;
    case (strobe.rdSel)
      RD_PRIO:
        for (int i = 1; i <= NUM_SRC; i++)
          if (strobe.idx == IDX_W'(i)) regRdata = DATA_W'(prioReg[i]);
      RD_EN:
        for (int c = 0; c < NUM_CTX; c++)
          if (strobe.idx == IDX_W'(c)) regRdata = DATA_W'({enReg[c], 1'b0});
      RD_THR:
        for (int c = 0; c < NUM_CTX; c++)
          if (strobe.idx == IDX_W'(c)) regRdata = DATA_W'(thrReg[c]);
      RD_CLAIM: regRdata = DATA_W'(claimId);
      default:  regRdata = '0;
    endcase
  end
endmodule

// File: rtl/hart_irq_router.sv
// Sources 1..NUM_SRC (at most 31), contexts 0..NUM_CTX-1 (at most 32).
// EDGE_MASK/QUEUE_MASK bit k-1 configures source k; resize them with NUM_SRC.
module hart_irq_router
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_CTX = 2,
  parameter int PRIO_W  = 3,
  parameter int QCNT_W  = 2,
  parameter logic [NUM_SRC-1:0] EDGE_MASK  = 8'hF0,
  parameter logic [NUM_SRC-1:0] QUEUE_MASK = 8'h30
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC:1]   irqSrc,
  input  logic               regWr,
  input  logic               regRd,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  regWdata,
  output logic [DATA_W-1:0]  regRdata,
  output logic [NUM_CTX-1:0] irqOut
);
  regStrobe_t       strobe;
  logic [NUM_SRC:1] pendVec;
  logic [NUM_SRC:1] busyVec;

  irqc_control #(
    .NUM_SRC (NUM_SRC),
    .NUM_CTX (NUM_CTX)
  ) u_control (
    .regWr    (regWr),
    .regRd    (regRd),
    .regAddr  (regAddr),
    .regWdata (regWdata),
    .strobe   (strobe)
  );

  irqc_datapath #(
    .NUM_SRC    (NUM_SRC),
    .NUM_CTX    (NUM_CTX),
    .PRIO_W     (PRIO_W),
    .QCNT_W     (QCNT_W),
    .EDGE_MASK  (EDGE_MASK),
    .QUEUE_MASK (QUEUE_MASK)
  ) u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .irqSrc   (irqSrc),
    .strobe   (strobe),
    .regRdata (regRdata),
    .irqOut   (irqOut),
    .pendVec  (pendVec),
    .busyVec  (busyVec)
  );
endmodule

// File: rtl/hart_irq_router_checker.sv
module hart_irq_router_checker
  import irqc_pkg::*;
#(
  parameter int NUM_SRC = 8,
  parameter int NUM_CTX = 2
) (
  input logic               clk,
  input logic               rst_n,
  input logic               regWr,
  input logic               regRd,
  input logic [ADDR_W-1:0]  regAddr,
  input logic [DATA_W-1:0]  regRdata,
  input logic [NUM_CTX-1:0] irqOut,
  input logic [NUM_SRC:1]   pendVec,
  input logic [NUM_SRC:1]   busyVec
);
  localparam int ID_W = $clog2(NUM_SRC + 1);

  logic            claimRead;
  logic [ID_W-1:0] rdId;
  logic [31:0]     irqWide;
  logic            ctxIrq;
  logic [NUM_SRC:0] pendFull;
  logic [NUM_SRC:0] busyFull;
  logic            claimedQ;
  logic [ID_W-1:0] claimedId;

  assign claimRead = regRd && !regWr
                     && (regAddr[ADDR_W-1:IDX_W] == REGION_CLAIM)
                     && (int'(regAddr[IDX_W-1:0]) < NUM_CTX);
  assign rdId     = regRdata[ID_W-1:0];
  assign irqWide  = 32'(irqOut);
  assign ctxIrq   = irqWide[regAddr[IDX_W-1:0]];
  assign pendFull = {pendVec, 1'b0};
  assign busyFull = {busyVec, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      claimedQ  <= 1'b0;
      claimedId <= '0;
    end else begin
      claimedQ  <= claimRead && (rdId != '0);
      claimedId <= rdId;
    end
  end

  assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (irqOut == '0));

  assert_irq_backed_by_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|irqOut) |-> (|pendVec));

  assert_empty_claim_no_irq_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (claimRead && rdId == '0) |-> !ctxIrq);

  assert_claim_enters_service_R4: assert property (@(posedge clk) disable iff (!rst_n)
    claimedQ |-> (busyFull[claimedId] && !pendFull[claimedId]));

  assert_pend_excludes_service_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((pendVec & busyVec) == '0));

  assert_claim_id_in_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    claimRead |-> (regRdata <= DATA_W'(NUM_SRC)));
endmodule

bind hart_irq_router hart_irq_router_checker #(
  .NUM_SRC (NUM_SRC),
  .NUM_CTX (NUM_CTX)
) u_checker (.*);

// File: tb/hart_irq_router_bench.sv
module hart_irq_router_bench;
  localparam int NUM_SRC = 8;
  localparam int NUM_CTX = 2;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [NUM_SRC:1]   irqSrc = '0;
  logic               regWr = 1'b0;
  logic               regRd = 1'b0;
  logic [6:0]         regAddr = '0;
  logic [31:0]        regWdata = '0;
  logic [31:0]        regRdata;
  logic [NUM_CTX-1:0] irqOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  hart_irq_router u_hart_irq_router (
    .clk, .rst_n, .irqSrc, .regWr, .regRd,
    .regAddr, .regWdata, .regRdata, .irqOut
  );

  function automatic logic [6:0] aPrio(int k);  return 7'(k); endfunction
  function automatic logic [6:0] aEn(int c);    return 7'(32 + c); endfunction
  function automatic logic [6:0] aThr(int c);   return 7'(64 + c); endfunction
  function automatic logic [6:0] aClaim(int c); return 7'(96 + c); endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(posedge clk); #1;
    regWr = 1'b0;
  endtask

  task automatic rd(logic [6:0] a, output logic [31:0] d);
    @(negedge clk);
    regRd = 1'b1; regAddr = a;
    #1 d = regRdata;
    @(posedge clk); #1;
    regRd = 1'b0;
  endtask

  task automatic claimExpect(int ctx, int exp, string req);
    logic [31:0] d;
    rd(aClaim(ctx), d);
    chk(req, d, 32'(exp));
  endtask

  task automatic irqExpect(logic [NUM_CTX-1:0] exp, string req);
    @(negedge clk);
    chk(req, 32'(irqOut), 32'(exp));
  endtask

  task automatic pulse(int s);
    @(negedge clk); irqSrc[s] = 1'b1;
    @(negedge clk); irqSrc[s] = 1'b0;
    @(negedge clk);
  endtask

  task automatic test_reset();
    logic [31:0] d;
    irqExpect(2'b00, "R1 irq after reset");
    rd(aPrio(1), d);  chk("R1 prio reset", d, 0);
    rd(aEn(1), d);    chk("R1 enable reset", d, 0);
    rd(aThr(0), d);   chk("R1 threshold reset", d, 0);
    rd(7'd100, d);    chk("R1 unused address", d, 0);
    claimExpect(0, 0, "R1 claim reset");
  endtask

  task automatic test_reserved();
    logic [31:0] d;
    wr(aPrio(0), 7);
    rd(aPrio(0), d);  chk("R9 prio word 0", d, 0);
    wr(aEn(0), 32'h1FF);
    rd(aEn(0), d);    chk("R9 enable bit0", d, 32'h1FE);
  endtask

  task automatic test_level_arbitration();
    wr(aPrio(1), 2); wr(aPrio(2), 5); wr(aPrio(3), 5); wr(aPrio(4), 1);
    wr(aEn(0), 32'h1E); wr(aEn(1), 32'h02);
    @(negedge clk); irqSrc[1] = 1; irqSrc[2] = 1; irqSrc[3] = 1;
    idle(2);
    irqExpect(2'b11, "R2 both contexts raised");
    claimExpect(0, 2, "R3 tie lower id");
    claimExpect(0, 3, "R3 next priority");
    irqExpect(2'b11, "R10 ctx1 still sees src1");
    claimExpect(1, 1, "R10 ctx1 claims own source");
    irqExpect(2'b00, "R4 all claimed");
    claimExpect(0, 0, "R4 no rerequest while in service");
  endtask

  task automatic test_threshold();
    wr(aThr(0), 5);
    wr(aClaim(0), 2);
    idle(2);
    irqExpect(2'b00, "R2 prio equal to threshold masked");
    wr(aThr(0), 4);
    irqExpect(2'b01, "R2 prio above threshold");
    claimExpect(0, 2, "R5 level repended after complete");
  endtask

  task automatic test_level_release();
    @(negedge clk); irqSrc[1] = 0; irqSrc[2] = 0; irqSrc[3] = 0;
    wr(aClaim(1), 1); wr(aClaim(0), 2); wr(aClaim(0), 3);
    wr(aThr(0), 0);
    idle(2);
    irqExpect(2'b00, "R5 low input no repend");
    claimExpect(0, 0, "R5 claim empty");
  endtask

  task automatic test_zero_priority();
    wr(aPrio(4), 0);
    @(negedge clk); irqSrc[4] = 1;
    idle(2);
    irqExpect(2'b00, "R2 priority zero never raises");
    claimExpect(0, 0, "R2 priority zero not claimable");
    @(negedge clk); irqSrc[4] = 0;
  endtask

  task automatic test_edge_queue();
    for (int k = 5; k <= 8; k++) wr(aPrio(k), 3);
    wr(aEn(0), 32'h1FE);
    pulse(5);
    irqExpect(2'b01, "R6 edge raises");
    claimExpect(0, 5, "R6 edge claim");
    for (int p = 0; p < 4; p++) pulse(5);
    irqExpect(2'b00, "R7 queued edges hidden while in service");
    for (int r = 0; r < 3; r++) begin
      wr(aClaim(0), 5);
      claimExpect(0, 5, "R7 replay after completion");
    end
    wr(aClaim(0), 5);
    claimExpect(0, 0, "R7 tally saturated at 3");
  endtask

  task automatic test_edge_hold();
    @(negedge clk); irqSrc[6] = 1;
    idle(2);
    claimExpect(0, 6, "R6 rising edge pends");
    wr(aClaim(0), 6);
    idle(3);
    claimExpect(0, 0, "R6 held high single request");
    @(negedge clk); irqSrc[6] = 0;
  endtask

  task automatic test_edge_discard();
    pulse(7);
    pulse(7);
    claimExpect(0, 7, "R8 discard edge claim");
    pulse(7);
    wr(aClaim(0), 7);
    idle(2);
    claimExpect(0, 0, "R8 busy edges dropped");
  endtask

  task automatic test_bad_complete();
    @(negedge clk); irqSrc[1] = 1;
    idle(2);
    claimExpect(0, 1, "R9 setup claim");
    wr(aClaim(0), 0);
    wr(aClaim(0), 9);
    idle(2);
    claimExpect(0, 0, "R9 bogus complete ignored");
    wr(aClaim(0), 1);
    idle(1);
    claimExpect(0, 1, "R9 real complete releases");
    @(negedge clk); irqSrc[1] = 0;
    wr(aClaim(0), 1);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    test_reset();
    test_reserved();
    test_level_arbitration();
    test_threshold();
    test_level_release();
    test_zero_priority();
    test_edge_queue();
    test_edge_hold();
    test_edge_discard();
    test_bad_complete();
    idle(2);
    finishRun();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end
endmodule